// File: doc/BRIEF.md
# Peripheral glue controller with interrupt masking

This block sits on the 8-bit bus of a small expansion unit and ties together a boot ROM, a floppy drive controller and a few general-purpose pins. It decodes each bus access into one of three selects: the ROM, the drive controller, or its own register page. On that page it holds three 8-bit write latches: an interrupt mask, output port B and output port C. It also holds a one-bit drive-reset latch. A read from the page returns one latch, or the live state of the 7-bit input port A, on a read data bus with an output-enable flag. The enable stands in for the pad tristate.

Each port A input is synchronised to the clock and ANDed with its bit of the mask latch. The OR of the seven masked sources drives a registered, level-sensitive interrupt request. All port pins are active low, while the logic inside the block is active high. A hardware reset clears the three latches and asserts the drive-reset pin. That pin stays asserted after reset is released until software clears it, and software can also assert it at any time.

Register offsets, in bits [1:0] within the register page, are: 0 = mask latch, 1 = port B latch, 2 = port C latch, 3 = drive-reset latch on write and port A on read. A register access also needs address bits [7:2] to be zero.

Top module: `xglue_top`

## Requirements
- R1: While `rst_n` is low, the three latches read as zero, `pb_n_o` and `pc_n_o` are 8'hFF, `irq_o` is 0 and `drv_rst_n_o` is 0.
- R2: A write (`wr_i` high) to page `REG_PAGE` (addr[15:8]) with addr[7:2]=0 stores `wdata_i` into the latch chosen by addr[1:0] at that clock edge.
- R3: `pb_n_o` equals the bitwise inverse of the port B latch, and `pc_n_o` equals the bitwise inverse of the port C latch.
- R4: With `rd_i` high on a register address, `rdata_oe_o` is 1 in the same cycle and `rdata_o` returns the mask, B or C latch for offsets 0 to 2. For offset 3 it returns {1'b0, synchronised active-high port A}. Otherwise `rdata_oe_o` is 0 and `rdata_o` is 0.
- R5: `irq_o` is 1 exactly when some bit i in 0..6 has port A input i active (pin `pa_n_i[i]` low) and mask bit i set. It is registered: it lags a mask write by one clock and a port A pin change by three clocks.
- R6: Mask latch bit 7 has no effect on `irq_o`.
- R7: `drv_rst_n_o` stays low after `rst_n` is released until a write to offset 3 with wdata bit 0 = 0. A write to offset 3 with bit 0 = 1 drives it low again on the next edge.
- R8: A write to offset 3 leaves the three latches unchanged, and a write to offsets 0 to 2 leaves `drv_rst_n_o` unchanged.
- R9: `rom_cs_n_o` is low exactly when `rd_i` or `wr_i` is high and addr[15] = 1. `fdd_cs_n_o` is low exactly when `rd_i` or `wr_i` is high and addr[15:8] = `FDD_PAGE`. Both are combinational.
- R10: A write whose address is outside the register page, or has a nonzero addr[7:2], changes no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asserted asynchronously and released synchronously |
| addr_i | input | 16 | Bus address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| rdata_oe_o | output | 1 | Read data drive enable |
| pa_n_i | input | 7 | Port A inputs, active low |
| pb_n_o | output | 8 | Port B outputs, active low |
| pc_n_o | output | 8 | Port C outputs, active low |
| irq_o | output | 1 | Masked interrupt request, active high |
| rom_cs_n_o | output | 1 | ROM select, active low |
| fdd_cs_n_o | output | 1 | Drive controller select, active low |
| drv_rst_n_o | output | 1 | Drive reset, active low |

## Verification
On every cycle, the assertions check these points:
- A write to a latch appears inverted on its pins one edge later.
- Pins and the drive-reset output hold unless their own register is written.
- The interrupt follows the previous cycle's masked, synchronised sources.
- At most one of the ROM select, the drive select, the read enable and a register write is active at once.

Only the bench scenarios can show the rest:
- The reset values and the sticky drive-reset state lasting past reset release.
- The readback values, including bit 7 of port A reading as zero.
- The three-clock path from a port A pin to the interrupt.
- Mask bit 7 having no effect.
- Writes to mirrored or foreign addresses being ignored.

// File: rtl/xglue_pkg.sv
package xglue_pkg;
  localparam int DW     = 8;
  localparam int PA_W   = 7;
  localparam int NLATCH = 3;
  localparam int NSEL   = NLATCH + 1;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_PB   = 2'd1,
    SEL_PC   = 2'd2,
    SEL_AUX  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/xglue_rst_sync.sv
module xglue_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/xglue_in_sync.sv
module xglue_in_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/xglue_decode.sv
module xglue_decode #(
  parameter int         ADDR_W   = 16,
  parameter int         PAGE_W   = 8,
  parameter logic [7:0] REG_PAGE = 8'h10,
  parameter logic [7:0] FDD_PAGE = 8'h11
) (
  input  logic              [ADDR_W-1:0] addr_i,
  input  logic                           wr_i,
  input  logic                           rd_i,
  output logic                           rom_cs_n_o,
  output logic                           fdd_cs_n_o,
  output logic [xglue_pkg::NSEL-1:0]     wr_sel_o,
  output logic                           rd_hit_o,
  output logic                    [1:0]  off_o
);
  localparam int LOW_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] page;
  logic              access;
  logic              reg_hit;

  assign page    = addr_i[ADDR_W-1 -: PAGE_W];
  assign access  = wr_i | rd_i;
  assign off_o   = addr_i[1:0];
  assign reg_hit = (page == PAGE_W'(REG_PAGE)) && (addr_i[LOW_W-1:2] == '0);

  assign rom_cs_n_o = ~(access & addr_i[ADDR_W-1]);
  assign fdd_cs_n_o = ~(access & (page == PAGE_W'(FDD_PAGE)));
  assign rd_hit_o   = rd_i & reg_hit;

  for (genvar i = 0; i < xglue_pkg::NSEL; i++) begin : g_wsel
    assign wr_sel_o[i] = wr_i & reg_hit & (off_o == 2'(i));
  end
endmodule

// File: rtl/xglue_top.sv
module xglue_top #(
  parameter int         ADDR_W   = 16,
  parameter int         PAGE_W   = 8,
  parameter logic [7:0] REG_PAGE = 8'h10,
  parameter logic [7:0] FDD_PAGE = 8'h11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        rdata_oe_o,
  input  logic [6:0]  pa_n_i,
  output logic [7:0]  pb_n_o,
  output logic [7:0]  pc_n_o,
  output logic        irq_o,
  output logic        rom_cs_n_o,
  output logic        fdd_cs_n_o,
  output logic        drv_rst_n_o
);
  import xglue_pkg::*;

  logic                        rst_s_n;
  logic [NSEL-1:0]             wr_sel;
  logic                        rd_hit;
  logic [1:0]                  off;
  logic [PA_W-1:0]             pa_s;
  logic [NLATCH-1:0][DW-1:0]   lat_q, lat_d;
  logic                        drv_q, drv_d;
  logic                        irq_q, irq_d;
  logic [DW-1:0]               rd_mux;

  xglue_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_s_n)
  );

  xglue_in_sync #(.W(PA_W)) u_pa (
    .clk(clk), .rst_n(rst_s_n), .d_i(~pa_n_i), .q_o(pa_s)
  );

  xglue_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .REG_PAGE(REG_PAGE), .FDD_PAGE(FDD_PAGE)
  ) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .rom_cs_n_o(rom_cs_n_o), .fdd_cs_n_o(fdd_cs_n_o),
    .wr_sel_o(wr_sel), .rd_hit_o(rd_hit), .off_o(off)
  );

  // latches: next state, then registers
  for (genvar i = 0; i < NLATCH; i++) begin : g_lat
    always_comb begin
      lat_d[i] = lat_q[i];
      if (wr_sel[i]) lat_d[i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) lat_q[i] <= '0;
      else          lat_q[i] <= lat_d[i];
    end
  end

  // sticky drive reset: comes out of reset asserted
  always_comb begin
    drv_d = drv_q;
    if (wr_sel[SEL_AUX]) drv_d = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) drv_q <= 1'b1;
    else          drv_q <= drv_d;
  end

  // masked interrupt, registered
  always_comb irq_d = |(pa_s & lat_q[SEL_MASK][PA_W-1:0]);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  // readback multiplexer
  always_comb begin
    unique case (reg_sel_e'(off))
      SEL_MASK: rd_mux = lat_q[SEL_MASK];
      SEL_PB:   rd_mux = lat_q[SEL_PB];
      SEL_PC:   rd_mux = lat_q[SEL_PC];
      default:  rd_mux = {{(DW-PA_W){1'b0}}, pa_s};
    endcase
  end

  assign rdata_o     = rd_hit ? rd_mux : '0;
  assign rdata_oe_o  = rd_hit;
  assign pb_n_o      = ~lat_q[SEL_PB];
  assign pc_n_o      = ~lat_q[SEL_PC];
  assign irq_o       = irq_q;
  assign drv_rst_n_o = ~drv_q;
endmodule

// File: rtl/xglue_chk.sv
module xglue_chk (
  input logic       clk,
  input logic       rst_s_n,
  input logic [3:0] wr_sel,
  input logic [7:0] wdata,
  input logic [6:0] pa_s,
  input logic [6:0] mask,
  input logic [7:0] pb_n,
  input logic [7:0] pc_n,
  input logic       irq,
  input logic       drv_rst_n,
  input logic       rd_en,
  input logic       rdata_oe,
  input logic       rom_cs_n,
  input logic       fdd_cs_n
);
  p_pb_load_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_sel[1] |=> pb_n == ~$past(wdata));

  p_pc_load_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_sel[2] |=> pc_n == ~$past(wdata));

  p_pb_hold_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_sel[1] |=> $stable(pb_n));

  p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_sel[2] |=> $stable(pc_n));

  p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq == |($past(pa_s) & $past(mask)));

  p_drv_set_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_sel[3] && wdata[0]) |=> !drv_rst_n);

  p_drv_clr_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_sel[3] && !wdata[0]) |=> drv_rst_n);

  p_drv_hold_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_sel[3] |=> $stable(drv_rst_n));

  p_oe_read_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    rdata_oe |-> rd_en);

  p_sel_excl_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({!rom_cs_n, !fdd_cs_n, rdata_oe, |wr_sel}));
endmodule

bind xglue_top xglue_chk u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .wr_sel(wr_sel), .wdata(wdata_i),
  .pa_s(pa_s), .mask(lat_q[0][6:0]), .pb_n(pb_n_o), .pc_n(pc_n_o),
  .irq(irq_o), .drv_rst_n(drv_rst_n_o), .rd_en(rd_i), .rdata_oe(rdata_oe_o),
  .rom_cs_n(rom_cs_n_o), .fdd_cs_n(fdd_cs_n_o)
);

// File: tb/sim_xglue_top.sv
module sim_xglue_top;
  localparam int K_PB = 0, K_PC = 1, K_IRQ = 2, K_DRV = 3, K_RD = 4,
                 K_OE = 5, K_ROM = 6, K_FDD = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        wr, rd;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        rdata_oe;
  logic [6:0]  pa_n;
  logic [7:0]  pb_n, pc_n;
  logic        irq, rom_cs_n, fdd_cs_n, drv_rst_n;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  int         kind_q[$];
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #4 clk = ~clk;

  xglue_top u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe), .pa_n_i(pa_n),
    .pb_n_o(pb_n), .pc_n_o(pc_n), .irq_o(irq), .rom_cs_n_o(rom_cs_n),
    .fdd_cs_n_o(fdd_cs_n), .drv_rst_n_o(drv_rst_n)
  );

  function automatic logic [7:0] observe(int k);
    case (k)
      K_PB:    return pb_n;
      K_PC:    return pc_n;
      K_IRQ:   return {7'd0, irq};
      K_DRV:   return {7'd0, drv_rst_n};
      K_RD:    return rdata;
      K_OE:    return {7'd0, rdata_oe};
      K_ROM:   return {7'd0, rom_cs_n};
      default: return {7'd0, fdd_cs_n};
    endcase
  endfunction

  // monitor: pops expectations and compares shortly before the next rising edge
  always @(negedge clk) begin
    #3;
    while (kind_q.size() > 0) begin
      int         k;
      logic [7:0] e, a;
      string      r;
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      r = req_q.pop_front();
      a = observe(k);
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: output %0d actual=%h expected=%h", r, k, a, e);
      end
    end
  end

  task automatic expect_out(int k, logic [7:0] e, string r);
    kind_q.push_back(k);
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    tick();
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0; addr = 16'h0000;
  endtask

  task automatic bus_rd(logic [15:0] a, logic [7:0] e, string r);
    tick();
    addr = a; rd = 1'b1;
    expect_out(K_OE, 8'h01, r);
    expect_out(K_RD, e, r);
    tick();
    rd = 1'b0; addr = 16'h0000;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr = 0; rd = 0; wdata = '0; pa_n = 7'h7F;
    repeat (3) tick();
    // R1 reset state
    expect_out(K_PB, 8'hFF, "R1");
    expect_out(K_PC, 8'hFF, "R1");
    expect_out(K_IRQ, 8'h00, "R1");
    expect_out(K_DRV, 8'h00, "R1");
    tick();
    rst_n = 1'b1;
    repeat (4) tick();
    expect_out(K_DRV, 8'h00, "R7");   // still held after release

    // R2 R3 port latches
    bus_wr(16'h1001, 8'hA5);
    expect_out(K_PB, 8'h5A, "R3");
    bus_wr(16'h1002, 8'h01);
    expect_out(K_PC, 8'hFE, "R3");
    bus_rd(16'h1001, 8'hA5, "R4");
    bus_rd(16'h1002, 8'h01, "R2");

    // R5 masking
    bus_wr(16'h1000, 8'h00);
    tick(); pa_n = 7'h00;
    repeat (3) tick();
    expect_out(K_IRQ, 8'h00, "R5");
    bus_rd(16'h1003, 8'h7F, "R4");
    bus_wr(16'h1000, 8'h04);
    tick();
    expect_out(K_IRQ, 8'h01, "R5");
    tick(); pa_n = ~7'h08;
    repeat (3) tick();
    expect_out(K_IRQ, 8'h00, "R5");
    bus_rd(16'h1003, 8'h08, "R4");
    tick(); pa_n = ~7'h04;
    repeat (3) tick();
    expect_out(K_IRQ, 8'h01, "R5");

    // R6 bit 7 of mask
    tick(); pa_n = 7'h00;
    bus_wr(16'h1000, 8'h80);
    repeat (4) tick();
    expect_out(K_IRQ, 8'h00, "R6");
    bus_rd(16'h1000, 8'h80, "R4");

    // R7 R8 drive reset
    bus_wr(16'h1003, 8'hFE);
    expect_out(K_DRV, 8'h01, "R7");
    expect_out(K_PB, 8'h5A, "R8");
    expect_out(K_PC, 8'hFE, "R8");
    bus_wr(16'h1003, 8'h01);
    expect_out(K_DRV, 8'h00, "R7");
    bus_wr(16'h1001, 8'h3C);
    expect_out(K_DRV, 8'h00, "R8");
    expect_out(K_PB, 8'hC3, "R2");
    bus_wr(16'h1003, 8'h00);
    expect_out(K_DRV, 8'h01, "R7");

    // R10 foreign and mirrored addresses
    bus_wr(16'h1201, 8'hFF);
    expect_out(K_PB, 8'hC3, "R10");
    bus_wr(16'h1005, 8'hFF);
    expect_out(K_PB, 8'hC3, "R10");
    bus_wr(16'h9002, 8'h77);
    expect_out(K_PC, 8'hFE, "R10");

    // R9 chip selects and R4 enable
    tick(); addr = 16'h8123; rd = 1'b1;
    expect_out(K_ROM, 8'h00, "R9");
    expect_out(K_FDD, 8'h01, "R9");
    expect_out(K_OE, 8'h00, "R4");
    expect_out(K_RD, 8'h00, "R4");
    tick(); rd = 1'b0; wr = 1'b1; addr = 16'h1140;
    expect_out(K_FDD, 8'h00, "R9");
    expect_out(K_ROM, 8'h01, "R9");
    tick(); wr = 1'b0;
    expect_out(K_FDD, 8'h01, "R9");
    tick(); addr = 16'hFFFF;
    expect_out(K_ROM, 8'h01, "R9");
    tick(); addr = 16'h0000;
    expect_out(K_PB, 8'hC3, "R10");

    // R1 second reset clears everything again
    tick(); rst_n = 1'b0;
    tick();
    expect_out(K_PB, 8'hFF, "R1");
    expect_out(K_PC, 8'hFF, "R1");
    expect_out(K_DRV, 8'h00, "R1");
    expect_out(K_IRQ, 8'h00, "R1");
    tick(); rst_n = 1'b1;
    repeat (4) tick();
    bus_rd(16'h1000, 8'h00, "R1");

    repeat (2) tick();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule